// File: doc/BRIEF.md
# Multi-Retire Reorder Buffer

This block keeps in-flight instructions in program order for an out-of-order core. It is a circular buffer of `ROB_SIZE` entries. Each cycle the issue stage may ask for up to `ISSUE_SIZE` new entries. The request is granted in full or not at all, and each granted slot receives a tag that identifies its entry. Entries complete out of order, in one of two ways. Register-writing instructions and branches complete from the result buses: `NUM_CDB` lanes, each carrying a tag, a value and a mispredict flag. Stores complete from a separate path that carries the effective address.

From the oldest entry onward, the block retires up to `COMMIT_SIZE` completed entries per cycle. Each retired register-writing entry produces a register-file write on the retire port. A store retires in one cycle and presents its address. A mispredicted branch is handled only when it is the oldest entry. It then retires alone, `flush_o` pulses for that cycle, and every younger entry is discarded. `ROB_SIZE` must be a power of two, and `COMMIT_SIZE` must not exceed it.

Top module: `rob_mc`

## Requirements
- R1: After reset the first tag granted is 0. `alloc_tag_o` is the tag given to slot 0 of a request, slot k receives `alloc_tag_o + k` modulo `ROB_SIZE`, and tags continue consecutively from one grant to the next.
- R2: `alloc_ok_o` is high exactly when no flush occurs in that cycle and `alloc_cnt_i` is no larger than the free entries at the start of the cycle, with this cycle's retirements not counted as free. A refused request allocates no slot.
- R3: While `rst_ni` is low the buffer is empty: `ret_valid_o` is 0, `flush_o` is 0 and `alloc_tag_o` is 0.
- R4: A valid result-bus lane whose tag names an occupied entry of kind ALU (code 0) or BRANCH (code 2) marks that entry complete and captures its value and mispredict flag. The lane has no effect on a STORE entry (code 1) or on a free entry.
- R5: The store path completes an occupied STORE entry with `st_addr_i` as its value. It has no effect on an entry of any other kind.
- R6: Retirement takes completed entries from the oldest entry onward, up to `COMMIT_SIZE` per cycle, and stops at the first entry that is not complete. Slot k of the retire port is the k-th oldest entry. A completion becomes eligible for retirement in the cycle after its broadcast.
- R7: `ret_we_o` is high only for retiring ALU entries, which present their destination on `ret_dst_o` and their value on `ret_data_o`. A retiring store shows its address on `ret_data_o` with `ret_we_o` low, and a retiring branch has `ret_we_o` low.
- R8: A completed branch with its mispredict flag set retires only in retire slot 0. If such a branch sits at slot k>0, retirement that cycle stops before it.
- R9: When a mispredicted branch retires, `flush_o` is high for that cycle only and no other slot retires. Every younger entry is discarded and any allocation request in that cycle is refused. The next tag granted is the branch's tag plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_cnt_i | input | CNT_W | Number of entries requested this cycle (0..ISSUE_SIZE) |
| alloc_kind_i | input | 2*ISSUE_SIZE | Kind per slot: 0 ALU, 1 STORE, 2 BRANCH |
| alloc_dst_i | input | REG_W*ISSUE_SIZE | Destination register per slot |
| alloc_ok_o | output | 1 | Request granted |
| alloc_tag_o | output | PTR_W | Tag of slot 0 |
| cdb_valid_i | input | NUM_CDB | Result lane valid |
| cdb_tag_i | input | PTR_W*NUM_CDB | Result lane tag |
| cdb_data_i | input | DATA_W*NUM_CDB | Result lane value |
| cdb_mispred_i | input | NUM_CDB | Branch outcome: mispredicted |
| st_valid_i | input | 1 | Store address valid |
| st_tag_i | input | PTR_W | Store entry tag |
| st_addr_i | input | DATA_W | Store effective address |
| ret_valid_o | output | COMMIT_SIZE | Retire slot valid, in program order |
| ret_we_o | output | COMMIT_SIZE | Register write per retire slot |
| ret_dst_o | output | REG_W*COMMIT_SIZE | Destination per retire slot |
| ret_data_o | output | DATA_W*COMMIT_SIZE | Value or address per retire slot |
| flush_o | output | 1 | Mispredict flush pulse |

## Verification
A directed run first fills the buffer with mixed kinds and requests one more entry, which shows the all-or-nothing refusal. It then completes entries out of order, so that the head holds back younger completed work. Stores are sent over the result bus and ALU tags over the store path, which shows that the wrong path is ignored. A mispredicted branch is placed both at slot 0 and at slot 1, which separates stopping before the branch from flushing at the head. A long random run then mixes grant sizes, duplicate and stale tags, and correctly predicted branches. A behavioural queue model is compared on every cycle.

// File: rtl/rob_mc_pkg.sv
package rob_mc_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2
  } kind_e;
endpackage

// File: rtl/rob_mc_alloc.sv
module rob_mc_alloc #(
  parameter int ROB_SIZE = 8,
  parameter int CNT_W    = 2,
  parameter int OCC_W    = 4
) (
  input  logic [OCC_W-1:0] count_i,
  input  logic [CNT_W-1:0] req_i,
  input  logic             flush_i,
  output logic             ok_o
);
  // free space judged before this cycle's retirements
  assign ok_o = !flush_i && ((int'(req_i) + int'(count_i)) <= ROB_SIZE);
endmodule

// File: rtl/rob_mc_complete.sv
module rob_mc_complete
  import rob_mc_pkg::*;
#(
  parameter int ROB_SIZE = 8,
  parameter int NUM_CDB  = 2,
  parameter int PTR_W    = 3,
  parameter int DATA_W   = 32
) (
  input  logic [ROB_SIZE-1:0]       v_i,
  input  kind_e                     kind_i [ROB_SIZE],
  input  logic [NUM_CDB-1:0]        cdb_valid_i,
  input  logic [NUM_CDB*PTR_W-1:0]  cdb_tag_i,
  input  logic [NUM_CDB*DATA_W-1:0] cdb_data_i,
  input  logic [NUM_CDB-1:0]        cdb_mispred_i,
  input  logic                      st_valid_i,
  input  logic [PTR_W-1:0]          st_tag_i,
  input  logic [DATA_W-1:0]         st_addr_i,
  output logic [ROB_SIZE-1:0]       set_o,
  output logic [ROB_SIZE-1:0]       set_mp_o,
  output logic [DATA_W-1:0]         set_data_o [ROB_SIZE]
);
  always_comb begin
    for (int i = 0; i < ROB_SIZE; i++) begin
      set_o[i]      = 1'b0;
      set_mp_o[i]   = 1'b0;
      set_data_o[i] = '0;
      for (int c = 0; c < NUM_CDB; c++) begin
        if (cdb_valid_i[c] && cdb_tag_i[c*PTR_W +: PTR_W] == PTR_W'(i) &&
            v_i[i] && kind_i[i] != K_STORE) begin
          set_o[i]      = 1'b1;
          set_mp_o[i]   = cdb_mispred_i[c];
          set_data_o[i] = cdb_data_i[c*DATA_W +: DATA_W];
        end
      end
      if (st_valid_i && st_tag_i == PTR_W'(i) && v_i[i] && kind_i[i] == K_STORE) begin
        set_o[i]      = 1'b1;
        set_mp_o[i]   = 1'b0;
        set_data_o[i] = st_addr_i;
      end
    end
  end
endmodule

// File: rtl/rob_mc_retire.sv
module rob_mc_retire
  import rob_mc_pkg::*;
#(
  parameter int ROB_SIZE    = 8,
  parameter int COMMIT_SIZE = 2,
  parameter int PTR_W       = 3,
  parameter int NRET_W      = 2,
  parameter int REG_W       = 5,
  parameter int DATA_W      = 32
) (
  input  logic [PTR_W-1:0]              head_i,
  input  logic [ROB_SIZE-1:0]           v_i,
  input  logic [ROB_SIZE-1:0]           done_i,
  input  logic [ROB_SIZE-1:0]           mp_i,
  input  kind_e                         kind_i [ROB_SIZE],
  input  logic [REG_W-1:0]              dst_i  [ROB_SIZE],
  input  logic [DATA_W-1:0]             data_i [ROB_SIZE],
  output logic [COMMIT_SIZE-1:0]        ret_valid_o,
  output logic [COMMIT_SIZE-1:0]        ret_we_o,
  output logic [COMMIT_SIZE*REG_W-1:0]  ret_dst_o,
  output logic [COMMIT_SIZE*DATA_W-1:0] ret_data_o,
  output logic [NRET_W-1:0]             nret_o,
  output logic                          flush_o
);
  logic [COMMIT_SIZE:0]   go;
  logic [COMMIT_SIZE-1:0] brmp;

  assign go[0] = 1'b1;

  for (genvar k = 0; k < COMMIT_SIZE; k++) begin : g_slot
    logic [PTR_W-1:0] idx;
    logic             ok;
    assign idx     = head_i + PTR_W'(k);
    assign ok      = v_i[idx] & done_i[idx];
    assign brmp[k] = (kind_i[idx] == K_BRANCH) & mp_i[idx];
    if (k == 0) begin : g_head
      assign ret_valid_o[k] = go[k] & ok;
    end else begin : g_young
      // a mispredicted branch waits until it is oldest
      assign ret_valid_o[k] = go[k] & ok & ~brmp[k];
    end
    assign go[k+1]                       = ret_valid_o[k] & ~brmp[k];
    assign ret_we_o[k]                   = ret_valid_o[k] & (kind_i[idx] == K_ALU);
    assign ret_dst_o[k*REG_W +: REG_W]   = dst_i[idx];
    assign ret_data_o[k*DATA_W +: DATA_W] = data_i[idx];
  end

  assign flush_o = ret_valid_o[0] & brmp[0];
  assign nret_o  = NRET_W'($countones(ret_valid_o));
endmodule

// File: rtl/rob_mc.sv
module rob_mc
  import rob_mc_pkg::*;
#(
  parameter int ROB_SIZE    = 8,
  parameter int ISSUE_SIZE  = 2,
  parameter int COMMIT_SIZE = 2,
  parameter int NUM_CDB     = 2,
  parameter int REG_W       = 5,
  parameter int DATA_W      = 32,
  localparam int PTR_W      = $clog2(ROB_SIZE),
  localparam int CNT_W      = $clog2(ISSUE_SIZE + 1),
  localparam int OCC_W      = $clog2(ROB_SIZE + 1),
  localparam int NRET_W     = $clog2(COMMIT_SIZE + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [CNT_W-1:0]              alloc_cnt_i,
  input  logic [ISSUE_SIZE*2-1:0]       alloc_kind_i,
  input  logic [ISSUE_SIZE*REG_W-1:0]   alloc_dst_i,
  output logic                          alloc_ok_o,
  output logic [PTR_W-1:0]              alloc_tag_o,
  input  logic [NUM_CDB-1:0]            cdb_valid_i,
  input  logic [NUM_CDB*PTR_W-1:0]      cdb_tag_i,
  input  logic [NUM_CDB*DATA_W-1:0]     cdb_data_i,
  input  logic [NUM_CDB-1:0]            cdb_mispred_i,
  input  logic                          st_valid_i,
  input  logic [PTR_W-1:0]              st_tag_i,
  input  logic [DATA_W-1:0]             st_addr_i,
  output logic [COMMIT_SIZE-1:0]        ret_valid_o,
  output logic [COMMIT_SIZE-1:0]        ret_we_o,
  output logic [COMMIT_SIZE*REG_W-1:0]  ret_dst_o,
  output logic [COMMIT_SIZE*DATA_W-1:0] ret_data_o,
  output logic                          flush_o
);
  logic [PTR_W-1:0]    head_q, tail_q;
  logic [OCC_W-1:0]    count_q;
  logic [ROB_SIZE-1:0] v_q, done_q, mp_q;
  kind_e               kind_q [ROB_SIZE];
  logic [REG_W-1:0]    dst_q  [ROB_SIZE];
  logic [DATA_W-1:0]   data_q [ROB_SIZE];

  logic [ROB_SIZE-1:0] set, set_mp;
  logic [DATA_W-1:0]   set_data [ROB_SIZE];
  logic [NRET_W-1:0]   nret;

  rob_mc_alloc #(.ROB_SIZE(ROB_SIZE), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_alloc (
    .count_i(count_q), .req_i(alloc_cnt_i), .flush_i(flush_o), .ok_o(alloc_ok_o)
  );

  rob_mc_complete #(.ROB_SIZE(ROB_SIZE), .NUM_CDB(NUM_CDB), .PTR_W(PTR_W),
                    .DATA_W(DATA_W)) u_cmpl (
    .v_i(v_q), .kind_i(kind_q),
    .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_data_i(cdb_data_i),
    .cdb_mispred_i(cdb_mispred_i),
    .st_valid_i(st_valid_i), .st_tag_i(st_tag_i), .st_addr_i(st_addr_i),
    .set_o(set), .set_mp_o(set_mp), .set_data_o(set_data)
  );

  rob_mc_retire #(.ROB_SIZE(ROB_SIZE), .COMMIT_SIZE(COMMIT_SIZE), .PTR_W(PTR_W),
                  .NRET_W(NRET_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_ret (
    .head_i(head_q), .v_i(v_q), .done_i(done_q), .mp_i(mp_q),
    .kind_i(kind_q), .dst_i(dst_q), .data_i(data_q),
    .ret_valid_o(ret_valid_o), .ret_we_o(ret_we_o), .ret_dst_o(ret_dst_o),
    .ret_data_o(ret_data_o), .nret_o(nret), .flush_o(flush_o)
  );

  assign alloc_tag_o = tail_q;

  // occupancy and pointers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      v_q     <= '0;
    end else if (flush_o) begin
      v_q     <= '0;
      head_q  <= head_q + PTR_W'(nret);
      tail_q  <= head_q + PTR_W'(nret);
      count_q <= '0;
    end else begin
      for (int k = 0; k < COMMIT_SIZE; k++)
        if (ret_valid_o[k]) v_q[head_q + PTR_W'(k)] <= 1'b0;
      if (alloc_ok_o)
        for (int k = 0; k < ISSUE_SIZE; k++)
          if (k < int'(alloc_cnt_i)) v_q[tail_q + PTR_W'(k)] <= 1'b1;
      head_q  <= head_q + PTR_W'(nret);
      tail_q  <= tail_q + (alloc_ok_o ? PTR_W'(alloc_cnt_i) : '0);
      count_q <= count_q - OCC_W'(nret) + (alloc_ok_o ? OCC_W'(alloc_cnt_i) : '0);
    end
  end

  // payload, qualified by v_q
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < ROB_SIZE; i++)
      if (set[i]) begin
        done_q[i] <= 1'b1;
        mp_q[i]   <= set_mp[i];
        data_q[i] <= set_data[i];
      end
    if (alloc_ok_o)
      for (int k = 0; k < ISSUE_SIZE; k++)
        if (k < int'(alloc_cnt_i)) begin
          done_q[tail_q + PTR_W'(k)] <= 1'b0;
          mp_q[tail_q + PTR_W'(k)]   <= 1'b0;
          kind_q[tail_q + PTR_W'(k)] <= kind_e'(alloc_kind_i[k*2 +: 2]);
          dst_q[tail_q + PTR_W'(k)]  <= alloc_dst_i[k*REG_W +: REG_W];
        end
  end
endmodule

// File: rtl/rob_mc_chk.sv
module rob_mc_chk #(
  parameter int ROB_SIZE    = 8,
  parameter int ISSUE_SIZE  = 2,
  parameter int COMMIT_SIZE = 2,
  localparam int CNT_W      = $clog2(ISSUE_SIZE + 1),
  localparam int OCC_W      = $clog2(ROB_SIZE + 1),
  localparam int NRET_W     = $clog2(COMMIT_SIZE + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [OCC_W-1:0]       count_i,
  input logic [NRET_W-1:0]      nret_i,
  input logic [CNT_W-1:0]       alloc_cnt_i,
  input logic                   alloc_ok_i,
  input logic [COMMIT_SIZE-1:0] ret_valid_i,
  input logic                   flush_i
);
  a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_i) <= ROB_SIZE);

  a_r2_grant_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ok_i |-> (int'(alloc_cnt_i) + int'(count_i) <= ROB_SIZE));

  a_r2_count_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> int'(count_i) == int'($past(count_i)) - int'($past(nret_i))
                 + ($past(alloc_ok_i) ? int'($past(alloc_cnt_i)) : 0));

  a_r8_flush_slot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> ret_valid_i == COMMIT_SIZE'(1));

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_i == '0);

  a_r9_flush_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !flush_i);

  for (genvar k = 1; k < COMMIT_SIZE; k++) begin : g_ord
    a_r6_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_valid_i[k] |-> ret_valid_i[k-1]);
  end
endmodule

bind rob_mc rob_mc_chk #(
  .ROB_SIZE(ROB_SIZE), .ISSUE_SIZE(ISSUE_SIZE), .COMMIT_SIZE(COMMIT_SIZE)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .count_i(count_q), .nret_i(nret),
  .alloc_cnt_i(alloc_cnt_i), .alloc_ok_i(alloc_ok_o),
  .ret_valid_i(ret_valid_o), .flush_i(flush_o)
);

// File: tb/rob_mc_tb_top.sv
module rob_mc_tb_top;
  localparam int RS = 8, IS = 2, CS = 2, NC = 2, RW = 5, DW = 32;
  localparam int PW = $clog2(RS), CW = $clog2(IS + 1);

  logic clk_i = 0, rst_ni = 0;
  always #2 clk_i = ~clk_i;

  logic [CW-1:0]    alloc_cnt_i;
  logic [IS*2-1:0]  alloc_kind_i;
  logic [IS*RW-1:0] alloc_dst_i;
  logic             alloc_ok_o;
  logic [PW-1:0]    alloc_tag_o;
  logic [NC-1:0]    cdb_valid_i, cdb_mispred_i;
  logic [NC*PW-1:0] cdb_tag_i;
  logic [NC*DW-1:0] cdb_data_i;
  logic             st_valid_i;
  logic [PW-1:0]    st_tag_i;
  logic [DW-1:0]    st_addr_i;
  logic [CS-1:0]    ret_valid_o, ret_we_o;
  logic [CS*RW-1:0] ret_dst_o;
  logic [CS*DW-1:0] ret_data_o;
  logic             flush_o;

  rob_mc #(.ROB_SIZE(RS), .ISSUE_SIZE(IS), .COMMIT_SIZE(CS), .NUM_CDB(NC),
           .REG_W(RW), .DATA_W(DW)) dut_i (.*);

  int total = 0, bad = 0;

  typedef struct { int kind; int dst; bit done; bit mp; logic [DW-1:0] data; int tag; } ent_t;
  ent_t q[$];
  int m_tail = 0;

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    alloc_cnt_i = '0; alloc_kind_i = '0; alloc_dst_i = '0;
    cdb_valid_i = '0; cdb_mispred_i = '0; cdb_tag_i = '0; cdb_data_i = '0;
    st_valid_i = 0; st_tag_i = '0; st_addr_i = '0;
  endtask

  task automatic set_alloc(int n, int k0, int d0, int k1, int d1);
    alloc_cnt_i = CW'(n);
    alloc_kind_i = {2'(k1), 2'(k0)};
    alloc_dst_i = {RW'(d1), RW'(d0)};
  endtask

  task automatic set_cdb(int l, int tag, int data, bit mp);
    cdb_valid_i[l] = 1;
    cdb_tag_i[l*PW +: PW] = PW'(tag);
    cdb_data_i[l*DW +: DW] = DW'(data);
    cdb_mispred_i[l] = mp;
  endtask

  task automatic set_st(int tag, int addr);
    st_valid_i = 1; st_tag_i = PW'(tag); st_addr_i = DW'(addr);
  endtask

  // one clock: inputs already driven; compare, then advance the model
  task automatic cyc(string rt);
    int nr; bit fl; bit ok; int brtag; logic [CS-1:0] mask;
    ent_t e;
    #1;
    nr = 0; fl = 0; brtag = 0;
    for (int k = 0; k < CS; k++) begin
      if (k >= q.size()) break;
      e = q[k];
      if (!e.done) break;
      if (e.kind == 2 && e.mp) begin
        if (k == 0) begin nr = 1; fl = 1; brtag = e.tag; end
        break;
      end
      nr++;
    end
    ok = !fl && (int'(alloc_cnt_i) <= RS - q.size());
    mask = '0;
    for (int k = 0; k < nr; k++) mask[k] = 1;
    chk(rt, ret_valid_o, mask);
    chk("R9", flush_o, fl);
    chk("R2", alloc_ok_o, ok);
    chk("R1", alloc_tag_o, m_tail % RS);
    for (int k = 0; k < nr; k++) begin
      e = q[k];
      chk("R7", ret_we_o[k], e.kind == 0);
      if (e.kind == 0) begin
        chk("R7", ret_dst_o[k*RW +: RW], e.dst);
        chk("R7", ret_data_o[k*DW +: DW], e.data);
      end
      if (e.kind == 1) chk("R7", ret_data_o[k*DW +: DW], e.data);
    end
    @(posedge clk_i);
    for (int k = 0; k < nr; k++) void'(q.pop_front());
    if (fl) begin
      q.delete();
      m_tail = (brtag + 1) % RS;
    end else begin
      for (int i = 0; i < q.size(); i++) begin
        e = q[i];
        for (int c = 0; c < NC; c++)
          if (cdb_valid_i[c] && int'(cdb_tag_i[c*PW +: PW]) == e.tag && e.kind != 1) begin
            e.done = 1; e.mp = cdb_mispred_i[c]; e.data = cdb_data_i[c*DW +: DW];
          end
        if (st_valid_i && int'(st_tag_i) == e.tag && e.kind == 1) begin
          e.done = 1; e.mp = 0; e.data = st_addr_i;
        end
        q[i] = e;
      end
      if (ok)
        for (int k = 0; k < int'(alloc_cnt_i); k++) begin
          e.kind = int'(alloc_kind_i[k*2 +: 2]); e.dst = int'(alloc_dst_i[k*RW +: RW]);
          e.done = 0; e.mp = 0; e.data = '0; e.tag = m_tail;
          q.push_back(e);
          m_tail = (m_tail + 1) % RS;
        end
    end
    @(negedge clk_i);
  endtask

  function automatic int pick_tag();
    if (q.size() > 0 && ($urandom % 4) != 0) return q[$urandom % q.size()].tag;
    return int'($urandom % RS);
  endfunction

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    chk("R3", ret_valid_o, 0);
    chk("R3", flush_o, 0);
    chk("R3", alloc_tag_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // fill: tags 0..7 = ALU ALU STORE ALU BRANCH ALU ALU ALU
    idle(); set_alloc(2, 0, 1, 0, 2); cyc("R1");
    idle(); set_alloc(2, 1, 3, 0, 4); cyc("R1");
    idle(); set_alloc(2, 2, 0, 0, 6); cyc("R1");
    idle(); set_alloc(2, 0, 7, 0, 8); cyc("R1");
    idle(); set_alloc(1, 0, 9, 0, 0); cyc("R2");        // full: refused
    idle(); set_cdb(0, 1, 'h11, 0); set_cdb(1, 3, 'h33, 0); cyc("R6");
    idle(); set_cdb(0, 2, 'hbad, 0); set_cdb(1, 0, 'h10, 0); cyc("R4");
    idle(); cyc("R6");                                   // retire 0,1
    idle(); set_st(3, 'hdead); cyc("R5");                // wrong kind: ignored
    idle(); set_st(2, 'ha000); cyc("R5");
    idle(); set_cdb(0, 4, 'h4, 1); set_cdb(1, 5, 'h55, 0); cyc("R7");
    idle(); set_alloc(1, 0, 9, 0, 0); cyc("R8");         // flush at head
    idle(); cyc("R9");
    // mispredicted branch first seen at slot 1
    idle(); set_alloc(2, 0, 10, 2, 0); cyc("R1");
    idle(); set_cdb(0, 5, 'h66, 0); set_cdb(1, 6, 'h6, 1); cyc("R6");
    idle(); cyc("R8");
    idle(); cyc("R8");
    idle(); cyc("R9");

    for (int n = 0; n < 3000; n++) begin
      idle();
      set_alloc(int'($urandom % 3), int'($urandom % 3), int'($urandom % 32),
                int'($urandom % 3), int'($urandom % 32));
      for (int c = 0; c < NC; c++)
        if ($urandom % 2) set_cdb(c, pick_tag(), int'($urandom), ($urandom % 5) == 0);
      if (cdb_valid_i[1] && cdb_valid_i[0] && cdb_tag_i[PW +: PW] == cdb_tag_i[0 +: PW])
        cdb_valid_i[1] = 0;
      if (($urandom % 3) == 0) set_st(pick_tag(), int'($urandom));
      cyc("R6");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule